// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Port

This block is the write-only control port of a camera analog front-end. A host drives a serial clock, a serial data line and an active-high strobe. While the strobe is low, each rising serial-clock edge shifts one bit into a 12-bit word. The first two bits form a register address and the remaining ten form the data word. The strobe's rising edge loads the word into one of four holding registers: front-end gain, auxiliary converter code, clamp reference level and control-pulse polarity.

The polarity settings take effect as soon as they are loaded. The gain, converter and clamp values pass through a second register stage. That stage copies all three holding values at once, on an edge of a vertical-sync input, so that analog settings change only between frames. The polarity register itself picks which sync edge commits. A system with no sync signal can tie the strobe to the sync input and choose the falling edge, so that each write commits as the strobe drops.

All four serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and every edge is detected in the system clock domain.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, gain, converter code, clamp level and every polarity bit read 0.
- R2: While the strobe is low, each rising serial-clock edge shifts the data bit in at the LSB of the word. A frame is sent address bit 1 first, then address bit 0, then data bits 9 down to 0.
- R3: A frame with more or fewer than 12 clock edges loads the last 12 bits shifted, including bits left over from the previous frame.
- R4: On the strobe's rising edge, word bits 11..10 select the holding register. 00 takes gain from data bits 8..0, 01 takes the converter code from bits 7..0, 10 takes the clamp level from bits 6..0, and 11 takes polarity. Data bits above each field are ignored even when written as 1.
- R5: The polarity register stores data bits 0 (sample pulses), 1 (pixel clock), 3 (black clamp), 5 (blanking) and 6 (sync edge). Bits 2 and 4 always read 0. The polarity output follows the load without waiting for a sync edge.
- R6: Loading gain, converter or clamp does not change the outputs. The selected sync edge copies all three holding values to the outputs together.
- R7: Polarity bit 6 = 0 makes the sync rising edge the commit edge, and 1 makes it the falling edge. The other edge commits nothing.
- R8: Serial-clock edges while the strobe is high do not shift the word. A second strobe with no shifts in between reloads the same word.
- R9: With the strobe tied to the sync input and falling-edge commit selected, a write is held while the strobe is high and reaches the outputs when the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_stb_i | input | 1 | Frame strobe, active high, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous, commit edge programmable |
| gain_o | output | 9 | Committed gain code |
| dac_o | output | 8 | Committed auxiliary converter code |
| clamp_o | output | 7 | Committed clamp reference level |
| pol_o | output | 7 | Polarity settings, bits 2 and 4 always 0 |

## Verification
The bench builds the block with its default widths: a 12-bit frame, a 2-bit address, and fields of 9, 8, 7 and 7 bits. These widths are small enough to sweep every converter code and every clamp level, each with its reserved bits set, and to cover the gain range in steps of seven. Directed sequences cover the sync-edge select in both settings, short and long frames, clock edges during the strobe, and the strobe-tied-to-sync commit.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 10;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int GAIN_W  = 9;
    localparam int DAC_W   = 8;
    localparam int CLAMP_W = 7;
    localparam int POL_W   = 7;
    localparam int POL_VS_BIT = 6;
    // writable polarity bits: 0,1,3,5,6
    localparam logic [POL_W-1:0] POL_KEEP = 7'b110_1011;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_GAIN  = 2'b00,
        SEL_DAC   = 2'b01,
        SEL_CLAMP = 2'b10,
        SEL_POL   = 2'b11
    } sel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = chain_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= stage_d;
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               stb_s,
    output logic [FRAME_W-1:0] word_o,
    output logic               load_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic               sclk_prev;
        logic               stb_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.stb_prev  = stb_s;
        if (sclk_s && !st_q.sclk_prev && !stb_s) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdat_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.shreg;
    assign load_o = stb_s && !st_q.stb_prev;

    // R8: strobe high freezes the word
    p_frozen_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stb_s |=> $stable(st_q.shreg));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_port_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FW-1:0]      word_i,
    input  logic               load_i,
    input  logic               vsync_s,
    output logic [GAIN_W-1:0]  gain_o,
    output logic [DAC_W-1:0]   dac_o,
    output logic [CLAMP_W-1:0] clamp_o,
    output logic [POL_W-1:0]   pol_o
);
    typedef struct packed {
        logic [GAIN_W-1:0]  hold_gain;
        logic [DAC_W-1:0]   hold_dac;
        logic [CLAMP_W-1:0] hold_clamp;
        logic [GAIN_W-1:0]  act_gain;
        logic [DAC_W-1:0]   act_dac;
        logic [CLAMP_W-1:0] act_clamp;
        logic [POL_W-1:0]   pol;
        logic               vs_prev;
    } regs_st_t;

    regs_st_t st_d, st_q;
    sel_e              sel;
    logic [DATA_W-1:0] payload;
    logic              vs_edge;

    always_comb begin
        sel     = sel_e'(word_i[FW-1 -: ADDR_W]);
        payload = word_i[DATA_W-1:0];
        vs_edge = st_q.pol[POL_VS_BIT] ? (!vsync_s &&  st_q.vs_prev)
                                       : ( vsync_s && !st_q.vs_prev);
        st_d         = st_q;
        st_d.vs_prev = vsync_s;
        if (vs_edge) begin
            st_d.act_gain  = st_q.hold_gain;
            st_d.act_dac   = st_q.hold_dac;
            st_d.act_clamp = st_q.hold_clamp;
        end
        if (load_i) begin
            unique case (sel)
                SEL_GAIN:  st_d.hold_gain  = payload[GAIN_W-1:0];
                SEL_DAC:   st_d.hold_dac   = payload[DAC_W-1:0];
                SEL_CLAMP: st_d.hold_clamp = payload[CLAMP_W-1:0];
                SEL_POL:   st_d.pol        = payload[POL_W-1:0] & POL_KEEP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gain_o  = st_q.act_gain;
    assign dac_o   = st_q.act_dac;
    assign clamp_o = st_q.act_clamp;
    assign pol_o   = st_q.pol;

    // R4: holding registers move only on a strobe load
    p_hold_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable({st_q.hold_gain, st_q.hold_dac, st_q.hold_clamp, st_q.pol}));

    // R5: unused polarity bits stay clear
    p_pol_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pol & ~POL_KEEP) == '0);

    // R6: outputs hold between commit edges
    p_commit_only_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_edge |=> $stable({gain_o, dac_o, clamp_o}));

    // R7: a commit edge copies the holding values seen before it
    p_commit_copies_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge |=> ({gain_o, dac_o, clamp_o} ==
                     $past({st_q.hold_gain, st_q.hold_dac, st_q.hold_clamp})));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               ser_stb_i,
    input  logic               vsync_i,
    output logic [GAIN_W-1:0]  gain_o,
    output logic [DAC_W-1:0]   dac_o,
    output logic [CLAMP_W-1:0] clamp_o,
    output logic [POL_W-1:0]   pol_o
);
    localparam int N_IN = 4;

    logic [N_IN-1:0]    raw_w, sync_w;
    logic [FRAME_W-1:0] word_w;
    logic               load_w;

    assign raw_w = {vsync_i, ser_stb_i, ser_dat_i, ser_clk_i};

    cfg_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (sync_w)
    );

    cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sync_w[0]),
        .sdat_s (sync_w[1]),
        .stb_s  (sync_w[2]),
        .word_o (word_w),
        .load_o (load_w)
    );

    cfg_regs #(.FW(FRAME_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (word_w),
        .load_i  (load_w),
        .vsync_s (sync_w[3]),
        .gain_o  (gain_o),
        .dac_o   (dac_o),
        .clamp_o (clamp_o),
        .pol_o   (pol_o)
    );
endmodule

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0, stb = 1'b0, vs = 1'b0, tie_vs = 1'b0;
    wire  vs_drv = tie_vs ? stb : vs;
    logic [8:0] gain_o;
    logic [7:0] dac_o;
    logic [6:0] clamp_o, pol_o;

    cfg_serial_port uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_stb_i(stb), .vsync_i(vs_drv),
        .gain_o(gain_o), .dac_o(dac_o), .clamp_o(clamp_o), .pol_o(pol_o)
    );

    int checks = 0, errors = 0;
    logic [11:0] m_shift = '0;
    logic [8:0]  m_hg = '0, m_g = '0;
    logic [7:0]  m_hd = '0, m_d = '0;
    logic [6:0]  m_hc = '0, m_c = '0, m_pol = '0;

    task automatic step();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req);
        chk(req, {23'd0, gain_o}, {23'd0, m_g});
        chk(req, {24'd0, dac_o}, {24'd0, m_d});
        chk(req, {25'd0, clamp_o}, {25'd0, m_c});
        chk(req, {25'd0, pol_o}, {25'd0, m_pol});
    endtask

    task automatic model_load();
        case (m_shift[11:10])
            2'b00: m_hg = m_shift[8:0];
            2'b01: m_hd = m_shift[7:0];
            2'b10: m_hc = m_shift[6:0];
            default: m_pol = m_shift[6:0] & 7'h6B;
        endcase
    endtask

    task automatic model_commit();
        m_g = m_hg; m_d = m_hd; m_c = m_hc;
    endtask

    task automatic shift_bit(logic b);
        sdat = b; step();
        sclk = 1'b1; step();
        sclk = 1'b0;
        m_shift = {m_shift[10:0], b};
    endtask

    task automatic shift_frame(logic [1:0] a, logic [9:0] d);
        logic [11:0] w;
        w = {a, d};
        for (int i = 11; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic strobe();
        stb = 1'b1; step(); model_load();
        stb = 1'b0; step();
    endtask

    task automatic send(logic [1:0] a, logic [9:0] d);
        shift_frame(a, d);
        strobe();
    endtask

    task automatic vs_pulse();
        vs = 1'b1; step();
        vs = 1'b0; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk_out("R1 reset");

        // R4/R6: gain with reserved bit 9 set, held until rising sync edge
        send(2'b00, 10'h355);
        chk_out("R6 no commit before sync");
        vs_pulse(); model_commit();
        chk("R4 gain field", {23'd0, gain_o}, 32'h155);
        chk_out("R6 commit on sync");

        // R3: long frame (5 junk bits before a 12-bit frame)
        for (int i = 0; i < 5; i++) shift_bit(1'b1);
        send(2'b01, 10'h0A5);
        vs_pulse(); model_commit();
        chk("R3 long frame", {24'd0, dac_o}, 32'hA5);
        // R3: short frame of 4 bits keeps previous tail
        for (int i = 0; i < 4; i++) shift_bit(i != 1);
        strobe();
        vs_pulse(); model_commit();
        chk("R3 short frame", {25'd0, clamp_o}, 32'h5B);
        chk_out("R3 outputs");

        // R8: clock edges while strobe high do not shift
        send(2'b10, 10'h02A);
        stb = 1'b1; sdat = 1'b1; step();
        for (int i = 0; i < 4; i++) begin
            sclk = 1'b1; step(); sclk = 1'b0; step();
        end
        stb = 1'b0; step();
        strobe();
        vs_pulse(); model_commit();
        chk("R8 frozen word", {25'd0, clamp_o}, 32'h2A);
        chk_out("R8 outputs");

        // R5: polarity with all bits set, immediate effect
        send(2'b11, 10'h3FF);
        chk("R5 polarity mask", {25'd0, pol_o}, 32'h6B);
        chk_out("R5 outputs");

        // R7: falling-edge commit selected
        send(2'b00, 10'h0F0);
        vs = 1'b1; step();
        chk("R7 rising ignored", {23'd0, gain_o}, {23'd0, m_g});
        vs = 1'b0; step(); model_commit();
        chk("R7 falling commits", {23'd0, gain_o}, 32'h0F0);

        // R9: strobe tied to sync, falling edge
        tie_vs = 1'b1;
        shift_frame(2'b00, 10'h1C3);
        stb = 1'b1; step(); model_load();
        chk("R9 held while strobe high", {23'd0, gain_o}, 32'h0F0);
        stb = 1'b0; step(); model_commit();
        chk("R9 commit on strobe fall", {23'd0, gain_o}, 32'h1C3);
        tie_vs = 1'b0; step();

        // R7: back to rising edge
        send(2'b11, 10'h000);
        chk("R7 polarity cleared", {25'd0, pol_o}, 32'h0);

        // R2/R4 sweeps with reserved bits set
        for (int v = 0; v < 256; v++) begin
            send(2'b01, {v[1:0], v[7:0]});
            vs_pulse(); model_commit();
            chk("R4 dac sweep", {24'd0, dac_o}, v);
        end
        for (int v = 0; v < 128; v++) begin
            send(2'b10, {v[2:0], v[6:0]});
            vs_pulse(); model_commit();
            chk("R2 clamp sweep", {25'd0, clamp_o}, v);
        end
        for (int v = 0; v < 512; v += 7) begin
            send(2'b00, {v[0], v[8:0]});
            vs_pulse(); model_commit();
            chk("R2 gain sweep", {23'd0, gain_o}, v);
            chk_out("R6 sweep outputs");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule